// File: doc/BRIEF.md
# Table-Driven Header Field Extractor

This block sits after header identification in a packet parser. Packet bytes arrive on a byte stream and are kept in a packet store. Identification records, each giving a header type and the byte position where that header starts, arrive on a separate handshake. For each record the block looks the header type up in a small extract table. The table lists up to four fields per type, and each field is given as a byte offset inside the header and a byte length. The block then copies those bytes out of the packet store into a register-based field buffer.

When the record marked as the last one of the packet has been handled, the whole field buffer is offered in parallel to downstream logic on a valid/ready handshake. While that offer waits, further records are refused, so fields already gathered cannot be overwritten. The extract table is written through a simple single-entry write port.

The controller is a five-state machine. S_IDLE accepts a record. S_LOOKUP reads the table and checks for room. S_COPY moves one byte per cycle. S_HDR_END decides whether the packet is complete. S_HOLD presents the buffer. The transitions are:
- S_IDLE to S_LOOKUP on an accepted record.
- S_LOOKUP to S_COPY when the fields fit, or to S_HDR_END when they do not.
- S_COPY to S_HDR_END after the fourth descriptor.
- S_HDR_END to S_HOLD for a last record, otherwise back to S_IDLE.
- S_HOLD to S_IDLE on the output handshake.

Top module: `fx_field_extractor`

## Requirements
- R1: After reset, out_valid, out_ovf and out_len are 0, and both hdr_ready and pkt_ready are 1.
- R2: A table write stores one descriptor (valid flag, 8-bit offset, length code L where the field is L+1 bytes) at the given type and slot. After reset every descriptor is invalid, so a type that was never written yields no bytes.
- R3: The byte copied for field byte i is packet byte hdr_offset + field offset + i, where packet byte 0 is the first byte received since the last output handshake. Fields are packed with no gaps, slot 0 first, bytes in ascending address order, starting at out_fields[7:0] (buffer byte k sits at out_fields[8k+7:8k]).
- R4: A descriptor whose valid flag is clear contributes no bytes, and the following slots pack directly after the previous field.
- R5: Fields of all records of a packet accumulate in arrival order. out_valid rises only after the record with hdr_last set has been fully processed.
- R6: When a field byte has not yet arrived, extraction waits for it. The result does not depend on the relative timing of bytes and records.
- R7: The field buffer holds 64 bytes. If a header's in-range fields would push the total past 64, none of them is written, and out_ovf is set and stays set until the output handshake. Later headers that fit are still written, and filling exactly 64 bytes is not an overflow.
- R8: The packet store holds 256 bytes (addresses 0 to 255). A field whose last byte address is 256 or more is skipped as if invalid. A field ending at address 255 is copied.
- R9: While out_valid is high, hdr_ready is low. While out_ready is low, out_fields, out_len and out_ovf hold their values.
- R10: After the output handshake, out_valid, out_len and out_ovf are 0, every buffer byte reads 0, and the next packet starts at byte address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Extract table write strobe |
| tbl_wr_type | input | 3 | Header type of the written entry |
| tbl_wr_slot | input | 2 | Descriptor slot within the entry |
| tbl_wr_vld | input | 1 | Descriptor valid flag |
| tbl_wr_off | input | 8 | Field byte offset within the header |
| tbl_wr_len_m1 | input | 2 | Field length minus one, in bytes |
| pkt_valid | input | 1 | Packet byte offered |
| pkt_data | input | 8 | Packet byte |
| pkt_ready | output | 1 | Packet store can take a byte |
| hdr_valid | input | 1 | Identification record offered |
| hdr_type | input | 3 | Identified header type |
| hdr_offset | input | 8 | Header start byte within the packet |
| hdr_last | input | 1 | Last record of the packet |
| hdr_ready | output | 1 | Record accepted this cycle when valid |
| out_valid | output | 1 | Field buffer complete |
| out_ready | input | 1 | Downstream takes the buffer |
| out_fields | output | 512 | Field buffer, byte k at bits 8k+7:8k |
| out_len | output | 7 | Number of filled buffer bytes |
| out_ovf | output | 1 | Some header's fields were dropped for lack of room |

## Verification
The block is driven with random extract tables and with packets carrying one to six records of random types and offsets. Byte gaps and record gaps are varied, so extraction sometimes waits on bytes still in flight and sometimes finds them already stored. A never-written table separates the reset contents from written ones. A hand-built entry mixing an invalid slot with different lengths separates packing order from slot position. Records near the end of the store separate the last in-range address from the first out-of-range one. Stacks of 16-byte headers separate an exact 64-byte fill from an overflow that is followed by a header that still fits. Holding out_ready low for several cycles separates a stable, backpressured output from one that changes under a stall.

// File: rtl/fx_pkg.sv
package fx_pkg;
    localparam int FX_OFF_W = 8;
    localparam int FX_LEN_W = 2;

    typedef struct packed {
        logic                vld;
        logic [FX_OFF_W-1:0] off;
        logic [FX_LEN_W-1:0] len_m1;
    } fx_desc_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOOKUP,
        S_COPY,
        S_HDR_END,
        S_HOLD
    } fx_state_e;
endpackage

// File: rtl/fx_extract_table.sv
module fx_extract_table
    import fx_pkg::*;
#(
    parameter int NUM_TYPES = 8,
    parameter int SLOTS     = 4,
    localparam int TYPE_W   = $clog2(NUM_TYPES),
    localparam int SL_W     = $clog2(SLOTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [TYPE_W-1:0]     wr_type,
    input  logic [SL_W-1:0]       wr_slot,
    input  fx_desc_t              wr_desc,
    input  logic [TYPE_W-1:0]     rd_type,
    output fx_desc_t [SLOTS-1:0]  rd_desc
);
    fx_desc_t [SLOTS-1:0] entry_q [NUM_TYPES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NUM_TYPES; t++) begin
                entry_q[t] <= '0;
            end
        end else if (wr_en) begin
            entry_q[wr_type][wr_slot] <= wr_desc;
        end
    end

    assign rd_desc = entry_q[rd_type];
endmodule

// File: rtl/fx_pkt_buffer.sv
module fx_pkt_buffer #(
    parameter int PKT_DEPTH = 256,
    localparam int PA_W     = $clog2(PKT_DEPTH),
    localparam int PC_W     = $clog2(PKT_DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [7:0]      in_data,
    output logic            in_ready,
    input  logic            clear,
    output logic [PC_W-1:0] cnt,
    input  logic [PA_W-1:0] rd_addr,
    output logic [7:0]      rd_data
);
    logic [7:0]      store_q [PKT_DEPTH];
    logic [PC_W-1:0] cnt_q;
    logic            take;

    assign in_ready = (cnt_q < PC_W'(PKT_DEPTH)) && !clear;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (take) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            store_q[cnt_q[PA_W-1:0]] <= in_data;
        end
    end

    assign cnt     = cnt_q;
    assign rd_data = store_q[rd_addr];
endmodule

// File: rtl/fx_field_buffer.sv
module fx_field_buffer #(
    parameter int FB_DEPTH = 64,
    localparam int FI_W    = $clog2(FB_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            wr_data,
    input  logic                  clear,
    output logic [FI_W-1:0]       fill,
    output logic [FB_DEPTH*8-1:0] data_flat
);
    logic [FI_W-1:0] fill_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (clear) begin
            fill_q <= '0;
        end else if (wr_en) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    for (genvar g = 0; g < FB_DEPTH; g++) begin : g_byte
        logic [7:0] byte_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (clear) begin
                byte_q <= '0;
            end else if (wr_en && (fill_q == FI_W'(g))) begin
                byte_q <= wr_data;
            end
        end
        assign data_flat[g*8 +: 8] = byte_q;
    end

    assign fill = fill_q;
endmodule

// File: rtl/fx_ctrl.sv
module fx_ctrl
    import fx_pkg::*;
#(
    parameter int NUM_TYPES = 8,
    parameter int SLOTS     = 4,
    parameter int PKT_DEPTH = 256,
    parameter int FB_DEPTH  = 64,
    localparam int TYPE_W   = $clog2(NUM_TYPES),
    localparam int SL_W     = $clog2(SLOTS),
    localparam int PA_W     = $clog2(PKT_DEPTH),
    localparam int PC_W     = $clog2(PKT_DEPTH + 1),
    localparam int FI_W     = $clog2(FB_DEPTH + 1),
    localparam int EA_W     = FX_OFF_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hdr_valid,
    input  logic [TYPE_W-1:0]    hdr_type,
    input  logic [FX_OFF_W-1:0]  hdr_offset,
    input  logic                 hdr_last,
    output logic                 hdr_ready,
    output logic [TYPE_W-1:0]    tbl_rd_type,
    input  fx_desc_t [SLOTS-1:0] tbl_rd_desc,
    input  logic [PC_W-1:0]      pkt_cnt,
    output logic [PA_W-1:0]      pkt_rd_addr,
    input  logic [7:0]           pkt_rd_data,
    input  logic [FI_W-1:0]      fb_fill,
    output logic                 fb_wr_en,
    output logic [7:0]           fb_wr_data,
    output logic                 fb_clear,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic                 out_ovf
);
    fx_state_e             state_q, state_d;
    logic [TYPE_W-1:0]     type_q;
    logic [FX_OFF_W-1:0]   base_q;
    logic                  last_q;
    fx_desc_t [SLOTS-1:0]  desc_q;
    logic [SL_W-1:0]       slot_q;
    logic [FX_LEN_W-1:0]   byte_q;
    logic                  ovf_q;

    // Screen table descriptors: drop fields running past the packet store
    // and total the bytes the remaining ones need.
    fx_desc_t [SLOTS-1:0]  desc_fit;
    int                    need;
    logic                  no_room;

    always_comb begin
        need = 0;
        for (int s = 0; s < SLOTS; s++) begin
            desc_fit[s] = tbl_rd_desc[s];
            if ((32'(base_q) + 32'(tbl_rd_desc[s].off) + 32'(tbl_rd_desc[s].len_m1))
                    >= 32'(PKT_DEPTH)) begin
                desc_fit[s].vld = 1'b0;
            end
            if (desc_fit[s].vld) begin
                need = need + 32'(tbl_rd_desc[s].len_m1) + 1;
            end
        end
    end

    assign no_room = (32'(fb_fill) + 32'(need)) > 32'(FB_DEPTH);

    // Copy datapath for the descriptor being walked
    fx_desc_t         cur_desc;
    logic [EA_W-1:0]  cur_addr;
    logic             byte_here;
    logic             slot_end;
    logic             fld_end;
    logic             step;

    assign cur_desc  = desc_q[slot_q];
    assign cur_addr  = EA_W'(base_q) + EA_W'(cur_desc.off) + EA_W'(byte_q);
    assign byte_here = 32'(cur_addr) < 32'(pkt_cnt);
    assign slot_end  = (slot_q == SL_W'(SLOTS - 1));
    assign fld_end   = (byte_q == cur_desc.len_m1);
    assign step      = cur_desc.vld ? (byte_here && fld_end) : 1'b1;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (hdr_valid) state_d = S_LOOKUP;
            S_LOOKUP:  state_d = no_room ? S_HDR_END : S_COPY;
            S_COPY:    if (step && slot_end) state_d = S_HDR_END;
            S_HDR_END: state_d = last_q ? S_HOLD : S_IDLE;
            S_HOLD:    if (out_ready) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        hdr_ready = 1'b0;
        out_valid = 1'b0;
        fb_clear  = 1'b0;
        fb_wr_en  = 1'b0;
        unique case (state_q)
            S_IDLE:    hdr_ready = 1'b1;
            S_COPY:    fb_wr_en  = cur_desc.vld && byte_here;
            S_HOLD: begin
                out_valid = 1'b1;
                fb_clear  = out_ready;
            end
            default: ;
        endcase
    end

    assign fb_wr_data  = pkt_rd_data;
    assign pkt_rd_addr = PA_W'(cur_addr);
    assign tbl_rd_type = type_q;
    assign out_ovf     = ovf_q;

    // Record, descriptor and walk registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            type_q <= '0;
            base_q <= '0;
            last_q <= 1'b0;
            desc_q <= '0;
            slot_q <= '0;
            byte_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (hdr_valid) begin
                        type_q <= hdr_type;
                        base_q <= hdr_offset;
                        last_q <= hdr_last;
                    end
                end
                S_LOOKUP: begin
                    desc_q <= desc_fit;
                    slot_q <= '0;
                    byte_q <= '0;
                    if (no_room) ovf_q <= 1'b1;
                end
                S_COPY: begin
                    if (cur_desc.vld && byte_here) begin
                        byte_q <= fld_end ? '0 : byte_q + 1'b1;
                    end
                    if (step) slot_q <= slot_q + 1'b1;
                end
                S_HOLD: begin
                    if (out_ready) ovf_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fx_field_extractor.sv
module fx_field_extractor
    import fx_pkg::*;
#(
    parameter int NUM_TYPES = 8,
    parameter int SLOTS     = 4,
    parameter int PKT_DEPTH = 256,
    parameter int FB_DEPTH  = 64,
    localparam int TYPE_W   = $clog2(NUM_TYPES),
    localparam int SL_W     = $clog2(SLOTS),
    localparam int PA_W     = $clog2(PKT_DEPTH),
    localparam int PC_W     = $clog2(PKT_DEPTH + 1),
    localparam int FI_W     = $clog2(FB_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tbl_wr_en,
    input  logic [TYPE_W-1:0]     tbl_wr_type,
    input  logic [SL_W-1:0]       tbl_wr_slot,
    input  logic                  tbl_wr_vld,
    input  logic [FX_OFF_W-1:0]   tbl_wr_off,
    input  logic [FX_LEN_W-1:0]   tbl_wr_len_m1,
    input  logic                  pkt_valid,
    input  logic [7:0]            pkt_data,
    output logic                  pkt_ready,
    input  logic                  hdr_valid,
    input  logic [TYPE_W-1:0]     hdr_type,
    input  logic [FX_OFF_W-1:0]   hdr_offset,
    input  logic                  hdr_last,
    output logic                  hdr_ready,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [FB_DEPTH*8-1:0] out_fields,
    output logic [FI_W-1:0]       out_len,
    output logic                  out_ovf
);
    fx_desc_t              wr_desc;
    fx_desc_t [SLOTS-1:0]  rd_desc;
    logic [TYPE_W-1:0]     rd_type;
    logic [PC_W-1:0]       pkt_cnt;
    logic [PA_W-1:0]       pkt_rd_addr;
    logic [7:0]            pkt_rd_data;
    logic                  fb_wr_en;
    logic [7:0]            fb_wr_data;
    logic                  fb_clear;

    assign wr_desc = '{vld: tbl_wr_vld, off: tbl_wr_off, len_m1: tbl_wr_len_m1};

    fx_extract_table #(.NUM_TYPES(NUM_TYPES), .SLOTS(SLOTS)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr_en),
        .wr_type (tbl_wr_type),
        .wr_slot (tbl_wr_slot),
        .wr_desc (wr_desc),
        .rd_type (rd_type),
        .rd_desc (rd_desc)
    );

    fx_pkt_buffer #(.PKT_DEPTH(PKT_DEPTH)) u_pkt (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (pkt_valid),
        .in_data  (pkt_data),
        .in_ready (pkt_ready),
        .clear    (fb_clear),
        .cnt      (pkt_cnt),
        .rd_addr  (pkt_rd_addr),
        .rd_data  (pkt_rd_data)
    );

    fx_field_buffer #(.FB_DEPTH(FB_DEPTH)) u_fbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (fb_wr_en),
        .wr_data   (fb_wr_data),
        .clear     (fb_clear),
        .fill      (out_len),
        .data_flat (out_fields)
    );

    fx_ctrl #(
        .NUM_TYPES (NUM_TYPES),
        .SLOTS     (SLOTS),
        .PKT_DEPTH (PKT_DEPTH),
        .FB_DEPTH  (FB_DEPTH)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .hdr_valid   (hdr_valid),
        .hdr_type    (hdr_type),
        .hdr_offset  (hdr_offset),
        .hdr_last    (hdr_last),
        .hdr_ready   (hdr_ready),
        .tbl_rd_type (rd_type),
        .tbl_rd_desc (rd_desc),
        .pkt_cnt     (pkt_cnt),
        .pkt_rd_addr (pkt_rd_addr),
        .pkt_rd_data (pkt_rd_data),
        .fb_fill     (out_len),
        .fb_wr_en    (fb_wr_en),
        .fb_wr_data  (fb_wr_data),
        .fb_clear    (fb_clear),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_ovf     (out_ovf)
    );
endmodule

// File: rtl/fx_field_extractor_chk.sv
module fx_field_extractor_chk #(
    parameter int FB_DEPTH = 64,
    localparam int FI_W    = $clog2(FB_DEPTH + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  hdr_ready,
    input logic                  out_valid,
    input logic                  out_ready,
    input logic [FB_DEPTH*8-1:0] out_fields,
    input logic [FI_W-1:0]       out_len,
    input logic                  out_ovf
);
    // R9: no record is taken while a finished buffer waits
    p_backpressure_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !hdr_ready);

    // R9: a stalled output keeps its contents
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_fields)
                                       && $stable(out_len) && $stable(out_ovf)));

    // R7: the overflow flag only clears through the handshake
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ovf && !(out_valid && out_ready)) |=> out_ovf);

    // R7: fill never passes the buffer size
    p_len_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_len <= FI_W'(FB_DEPTH));

    // R5: fill only grows within a packet
    p_len_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_ready) |=> out_len >= $past(out_len));

    // R10: handshake empties the buffer
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (!out_valid && out_len == '0 && !out_ovf));
endmodule

bind fx_field_extractor fx_field_extractor_chk #(.FB_DEPTH(FB_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hdr_ready  (hdr_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_fields (out_fields),
    .out_len    (out_len),
    .out_ovf    (out_ovf)
);

// File: tb/fx_field_extractor_tb.sv
module fx_field_extractor_tb_top;
    localparam int NT = 8;
    localparam int PD = 256;
    localparam int FD = 64;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tbl_wr_en = 1'b0;
    logic [2:0]     tbl_wr_type = '0;
    logic [1:0]     tbl_wr_slot = '0;
    logic           tbl_wr_vld = 1'b0;
    logic [7:0]     tbl_wr_off = '0;
    logic [1:0]     tbl_wr_len_m1 = '0;
    logic           pkt_valid = 1'b0;
    logic [7:0]     pkt_data = '0;
    logic           pkt_ready;
    logic           hdr_valid = 1'b0;
    logic [2:0]     hdr_type = '0;
    logic [7:0]     hdr_offset = '0;
    logic           hdr_last = 1'b0;
    logic           hdr_ready;
    logic           out_valid;
    logic           out_ready = 1'b0;
    logic [FD*8-1:0] out_fields;
    logic [6:0]     out_len;
    logic           out_ovf;

    always #4 clk = ~clk;

    fx_field_extractor dut_i (.*);

    int checks = 0;
    int fails  = 0;

    bit       m_vld [NT][4];
    int       m_off [NT][4];
    int       m_len [NT][4];
    bit [7:0] pkt [PD];
    int       n_rec;
    int       r_type [8];
    int       r_off  [8];
    int              e_len;
    bit              e_ovf;
    logic [FD*8-1:0] exp_vec;
    bit       last_sent;
    bit       bytes_done;

    task automatic check(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    task automatic tbl_put(input int t, input int s, input bit v, input int o, input int l);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_type = 3'(t); tbl_wr_slot = 2'(s);
        tbl_wr_vld = v; tbl_wr_off = 8'(o); tbl_wr_len_m1 = 2'(l - 1);
        m_vld[t][s] = v; m_off[t][s] = o; m_len[t][s] = l;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    // Reference: R3 packing, R4 invalid skip, R7 room rule, R8 range rule
    function automatic void model();
        e_len = 0; e_ovf = 0; exp_vec = '0;
        for (int k = 0; k < n_rec; k++) begin
            int t = r_type[k];
            int need = 0;
            for (int s = 0; s < 4; s++)
                if (m_vld[t][s] && (r_off[k] + m_off[t][s] + m_len[t][s] - 1) < PD)
                    need += m_len[t][s];
            if (e_len + need > FD) begin
                e_ovf = 1;
            end else begin
                for (int s = 0; s < 4; s++)
                    if (m_vld[t][s] && (r_off[k] + m_off[t][s] + m_len[t][s] - 1) < PD)
                        for (int i = 0; i < m_len[t][s]; i++) begin
                            exp_vec[e_len*8 +: 8] = pkt[r_off[k] + m_off[t][s] + i];
                            e_len++;
                        end
            end
        end
    endfunction

    task automatic send_bytes(input int gmax);
        for (int i = 0; i < PD; i++) begin
            int g = (gmax == 0) ? 0 : int'($urandom % (gmax + 1));
            repeat (g) begin @(negedge clk); pkt_valid = 1'b0; end
            @(negedge clk);
            pkt_valid = 1'b1; pkt_data = pkt[i];
            while (!pkt_ready) @(negedge clk);
        end
        @(negedge clk);
        pkt_valid = 1'b0;
        bytes_done = 1;
    endtask

    task automatic send_recs(input int gmax);
        for (int k = 0; k < n_rec; k++) begin
            int g = (gmax == 0) ? 0 : int'($urandom % (gmax + 1));
            repeat (g) begin @(negedge clk); hdr_valid = 1'b0; end
            @(negedge clk);
            hdr_valid = 1'b1; hdr_type = 3'(r_type[k]);
            hdr_offset = 8'(r_off[k]); hdr_last = (k == n_rec - 1);
            while (!hdr_ready) @(negedge clk);
            if (k == n_rec - 1) last_sent = 1;
        end
        @(negedge clk);
        hdr_valid = 1'b0;
    endtask

    task automatic take_out(input string req, input int hold);
        logic [FD*8-1:0] f0;
        logic [6:0] l0;
        logic o0;
        @(negedge clk);
        while (!out_valid) @(negedge clk);
        check(last_sent, "R5", "out_valid before last record was accepted");
        f0 = out_fields; l0 = out_len; o0 = out_ovf;
        for (int h = 0; h < hold || !bytes_done; h++) begin
            @(negedge clk);
            check(out_valid && out_fields == f0 && out_len == l0 && out_ovf == o0 && !hdr_ready,
                  "R9", $sformatf("stall changed: valid=%0b len=%0d/%0d ovf=%0b/%0b hdr_ready=%0b exp 0",
                                  out_valid, out_len, l0, out_ovf, o0, hdr_ready));
        end
        check(out_len == 7'(e_len), req, $sformatf("len act=%0d exp=%0d", out_len, e_len));
        check(out_ovf == e_ovf, req, $sformatf("ovf act=%0b exp=%0b", out_ovf, e_ovf));
        check(out_fields == exp_vec, req, $sformatf("fields act=%h exp=%h", out_fields, exp_vec));
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check(!out_valid && out_len == 0 && !out_ovf && out_fields == '0, "R10",
              $sformatf("after handshake valid=%0b len=%0d ovf=%0b exp 0/0/0", out_valid, out_len, out_ovf));
    endtask

    task automatic run_pkt(input string req, input int bgap, input int rgap, input int hold);
        for (int i = 0; i < PD; i++) pkt[i] = 8'($urandom);
        model();
        last_sent = 0; bytes_done = 0;
        fork
            send_bytes(bgap);
            send_recs(rgap);
            take_out(req, hold);
        join
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: run hung, act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int t = 0; t < NT; t++)
            for (int s = 0; s < 4; s++) begin
                m_vld[t][s] = 0; m_off[t][s] = 0; m_len[t][s] = 1;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!out_valid && !out_ovf && out_len == 0 && hdr_ready && pkt_ready, "R1",
              $sformatf("valid=%0b ovf=%0b len=%0d hr=%0b pr=%0b exp 0 0 0 1 1",
                        out_valid, out_ovf, out_len, hdr_ready, pkt_ready));

        // R2: never-written table gives nothing
        n_rec = 2; r_type[0] = 3; r_off[0] = 0; r_type[1] = 5; r_off[1] = 10;
        run_pkt("R2", 0, 0, 0);

        // R3, R4: mixed lengths with an invalid slot
        tbl_put(1, 0, 1, 2, 2);
        tbl_put(1, 1, 0, 9, 3);
        tbl_put(1, 2, 1, 0, 1);
        tbl_put(1, 3, 1, 7, 4);
        n_rec = 1; r_type[0] = 1; r_off[0] = 14;
        run_pkt("R3", 0, 0, 2);
        n_rec = 1; r_type[0] = 1; r_off[0] = 0;
        run_pkt("R4", 1, 0, 0);

        // R8: end-of-store boundary
        tbl_put(2, 0, 1, 5, 1);
        tbl_put(2, 1, 1, 5, 2);
        tbl_put(2, 2, 1, 4, 2);
        tbl_put(2, 3, 0, 0, 1);
        n_rec = 1; r_type[0] = 2; r_off[0] = 250;
        run_pkt("R8", 0, 0, 0);

        // R6: records first, bytes trickle in
        n_rec = 2; r_type[0] = 1; r_off[0] = 200; r_type[1] = 2; r_off[1] = 240;
        run_pkt("R6", 3, 0, 1);

        // R7: exact fill, then overflow followed by a header that fits
        for (int s = 0; s < 4; s++) tbl_put(4, s, 1, s * 4, 4);
        n_rec = 4;
        for (int k = 0; k < 4; k++) begin r_type[k] = 4; r_off[k] = k * 16; end
        run_pkt("R7", 0, 0, 0);
        n_rec = 6;
        for (int k = 0; k < 3; k++) begin r_type[k] = 4; r_off[k] = k * 20; end
        r_type[3] = 1; r_off[3] = 70;
        r_type[4] = 4; r_off[4] = 90;
        r_type[5] = 2; r_off[5] = 100;
        run_pkt("R7", 1, 2, 3);

        // R5, R6: random tables and packets
        for (int p = 0; p < 40; p++) begin
            if (p % 5 == 0)
                for (int t = 0; t < NT; t++)
                    for (int s = 0; s < 4; s++)
                        tbl_put(t, s, ($urandom % 4) != 0, int'($urandom % 64), int'($urandom % 4) + 1);
            n_rec = int'($urandom % 6) + 1;
            for (int k = 0; k < n_rec; k++) begin
                r_type[k] = int'($urandom % NT);
                r_off[k]  = int'($urandom % 240);
            end
            run_pkt("R5", int'($urandom % 3), int'($urandom % 4), int'($urandom % 4));
        end

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule